// File: doc/BRIEF.md
# Run-Length Coefficient Block Decoder

This block turns a stream of 16-bit compressed halfwords into one complete 64-entry coefficient block. It emits one write per entry: a store address, the raw signed coefficient and the block's scale value. A dequantizer and a block RAM downstream take these writes. Every position of the block is written exactly once. Skipped positions get explicit zero writes, so the RAM needs no clearing pass between blocks.

A halfword has two parts. Bits 15..10 form a 6-bit field and bits 9..0 form a signed 10-bit coefficient. In the first word of a block, the field is the block's scale. In each later word, the field is the number of zero entries that come before the coefficient. The code 0xFE00 has two meanings. As a first word it is padding and is dropped. After the first word it ends the block, and every remaining position is filled with zeros.

Both data edges use valid/ready. An input word is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends only on internal state and never on `in_valid` or `out_ready`. An output beat transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat is held unchanged.

Top module: `rl_block_decoder`

## Requirements
- R1: `out_coef` on the write for a coefficient word equals bits 9..0 of that word unchanged, including the negative codes 0x200..0x3FF.
- R2: The first non-padding word of a block gives its bits 15..10 as the scale. That value appears on `out_scale` for all 64 writes of the block, and the word's coefficient is written at position 0.
- R3: The code 0xFE00 received as a first word produces no write. The next word is still treated as the first word.
- R4: A later word with run field r produces r zero writes at the next r positions, then one write of its coefficient at the position after them.
- R5: The code 0xFE00 received after the first word produces zero writes for every remaining position up to 63, and this ends the block.
- R6: If a run would go past position 63, zero writes stop at 63, the word's coefficient is dropped, and the next word starts a new block.
- R7: With a nonzero scale, the address for position k is the raster index (8*row + col) of the k-th cell of the zigzag scan. The scan starts 00, 01, 08, 10, 09, 02, 03, 0A and ends at 3F.
- R8: With a scale of zero, the address equals the position (0..63) and no reordering is done.
- R9: Every block produces exactly 64 writes. `out_last` and `block_done` are high only on the write to position 63, and `block_done` pulses on the cycle that write is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr`, `out_coef`, `out_scale` and `out_last` do not change.
- R11: After a non-padding word is accepted, `in_ready` is low in the following cycle. It stays low until all writes owed to that word have been issued, and at most one write is issued per cycle.
- R12: After reset, `out_valid` and `block_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input halfword is valid |
| in_ready | output | 1 | Decoder can accept a halfword |
| in_data | input | 16 | Compressed halfword: field in 15..10, coefficient in 9..0 |
| out_valid | output | 1 | Write beat is valid |
| out_ready | input | 1 | Downstream accepts the write beat |
| out_addr | output | 6 | Store address in the block |
| out_coef | output | 10 | Signed raw coefficient, zero for skipped positions |
| out_scale | output | 6 | Scale of the current block |
| out_last | output | 1 | This beat writes position 63 |
| block_done | output | 1 | Final write of the block is being accepted |

## Verification
A wrong position count shows up at once as a wrong `out_addr` on the next write. It also moves `out_last` away from the 64th beat, so the failure is never hidden for longer than one block. A run counter that is off by one gives one zero write too many or too few. Every later address in that block then slips by one place, and the coefficient lands in the wrong cell. A stuck first-word flag is caught on the next block boundary: padding turns into a write, or a scale value is read as a run. The bench follows each beat in order against a model of all 64 writes per block, and randomises stall patterns on both edges. Holding faults and early `in_ready` are therefore seen within one cycle.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  localparam int DEF_SIDE    = 8;
  localparam int DEF_FIELD_W = 6;
  localparam int DEF_COEF_W  = 10;
  localparam logic [15:0] DEF_END_CODE = 16'hFE00;

  typedef enum logic [1:0] {
    WK_PAD   = 2'd0,
    WK_FIRST = 2'd1,
    WK_RUN   = 2'd2,
    WK_END   = 2'd3
  } word_kind_e;

endpackage

// File: rtl/rlc_word_parser.sv
module rlc_word_parser
  import rlc_pkg::*;
#(
  parameter int FIELD_W = DEF_FIELD_W,
  parameter int COEF_W  = DEF_COEF_W,
  parameter logic [FIELD_W+COEF_W-1:0] END_CODE = DEF_END_CODE
) (
  input  logic [FIELD_W+COEF_W-1:0] word,
  input  logic                      first,
  output word_kind_e                kind,
  output logic [FIELD_W-1:0]        field,
  output logic [COEF_W-1:0]         coef
);

  assign field = word[FIELD_W+COEF_W-1:COEF_W];
  assign coef  = word[COEF_W-1:0];

  always_comb begin
    if (word == END_CODE) kind = first ? WK_PAD : WK_END;
    else                  kind = first ? WK_FIRST : WK_RUN;
  end

endmodule

// File: rtl/rlc_run_counter.sv
module rlc_run_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_nz
);

  logic load_nz_q;
  logic finished_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      load_nz_q  <= 1'b0;
      finished_q <= 1'b0;
    end else begin
      finished_q <= 1'b0;
      if (clr) begin
        cnt       <= '0;
        load_nz_q <= 1'b0;
      end else if (load) begin
        cnt       <= load_val;
        load_nz_q <= (load_val != '0);
      end else if (dec && cnt_nz) begin
        cnt        <= cnt - 1'b1;
        finished_q <= (cnt == CNT_W'(1));
      end
    end
  end

  assign cnt_nz = (cnt != '0);

  // R4: a single remaining skip ends the run on the next cycle
  a_r4_run_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !load && cnt == CNT_W'(1)) |=> (finished_q && !cnt_nz));

  // R4: completion is only ever reported for a run loaded nonzero
  a_r4_finish_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    finished_q |-> load_nz_q);

  // R4: each skip removes exactly one from the remaining run
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rlc_pos_counter.sv
module rlc_pos_counter #(
  parameter int N_ENT = 64,
  localparam int POS_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [POS_W-1:0] pos,
  output logic             pos_last
);

  logic pos_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pos <= '0;
    else if (clr) pos <= '0;
    else if (inc) pos <= pos + 1'b1;
  end

  assign pos_last = (pos == POS_W'(N_ENT - 1));
  assign pos_nz   = (pos != '0);

  // R9: each write advances the position by one
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (pos == $past(pos) + 1'b1));

  // R9: closing a block returns the position to zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pos_nz);

endmodule

// File: rtl/rlc_scan_map.sv
module rlc_scan_map #(
  parameter int SIDE = 8,
  localparam int N_ENT = SIDE * SIDE,
  localparam int POS_W = $clog2(N_ENT)
) (
  input  logic [POS_W-1:0] pos,
  input  logic             bypass,
  output logic [POS_W-1:0] addr
);

  function automatic logic [N_ENT*POS_W-1:0] build_scan();
    logic [N_ENT*POS_W-1:0] t;
    int k;
    int r;
    int c;
    t = '0;
    k = 0;
    for (int s = 0; s < 2*SIDE-1; s++) begin
      for (int i = 0; i < SIDE; i++) begin
        r = (s % 2 == 0) ? (SIDE - 1 - i) : i;
        c = s - r;
        if (c >= 0 && c < SIDE) begin
          t[k*POS_W +: POS_W] = POS_W'(r*SIDE + c);
          k++;
        end
      end
    end
    return t;
  endfunction

  localparam logic [N_ENT*POS_W-1:0] SCAN_TBL = build_scan();

  assign addr = bypass ? pos : SCAN_TBL[int'(pos)*POS_W +: POS_W];

endmodule

// File: rtl/rl_block_decoder.sv
module rl_block_decoder
  import rlc_pkg::*;
#(
  parameter int SIDE    = DEF_SIDE,
  parameter int FIELD_W = DEF_FIELD_W,
  parameter int COEF_W  = DEF_COEF_W,
  localparam int WORD_W = FIELD_W + COEF_W,
  localparam int N_ENT  = SIDE * SIDE,
  localparam int POS_W  = $clog2(N_ENT),
  localparam int RUN_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [POS_W-1:0]  out_addr,
  output logic [COEF_W-1:0] out_coef,
  output logic [FIELD_W-1:0] out_scale,
  output logic              out_last,
  output logic              block_done
);

  logic               first_q;
  logic               pend_q;
  logic [COEF_W-1:0]  pend_coef_q;
  logic [FIELD_W-1:0] scale_q;

  word_kind_e         kind;
  logic [FIELD_W-1:0] w_field;
  logic [COEF_W-1:0]  w_coef;

  logic [RUN_W-1:0]   run_cnt;
  logic               run_nz;
  logic [POS_W-1:0]   pos;
  logic               pos_last;
  logic [POS_W-1:0]   map_addr;

  logic slot_free, emit_zero, emit_coef, emit, accept, close_blk;
  logic run_load;
  logic [RUN_W-1:0] run_load_val;

  rlc_word_parser #(
    .FIELD_W (FIELD_W),
    .COEF_W  (COEF_W),
    .END_CODE(WORD_W'(DEF_END_CODE))
  ) u_parse (
    .word (in_data),
    .first(first_q),
    .kind (kind),
    .field(w_field),
    .coef (w_coef)
  );

  assign slot_free = !out_valid || out_ready;
  assign emit_zero = slot_free && run_nz;
  assign emit_coef = slot_free && !run_nz && pend_q;
  assign emit      = emit_zero || emit_coef;
  assign close_blk = emit && pos_last;
  assign in_ready  = !run_nz && !pend_q;
  assign accept    = in_valid && in_ready;

  assign run_load     = accept && (kind == WK_RUN || kind == WK_END);
  assign run_load_val = (kind == WK_END) ? (RUN_W'(N_ENT) - RUN_W'(pos))
                                         : RUN_W'(w_field);

  rlc_run_counter #(.CNT_W(RUN_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (close_blk),
    .load    (run_load),
    .load_val(run_load_val),
    .dec     (emit_zero),
    .cnt     (run_cnt),
    .cnt_nz  (run_nz)
  );

  rlc_pos_counter #(.N_ENT(N_ENT)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (close_blk),
    .inc     (emit),
    .pos     (pos),
    .pos_last(pos_last)
  );

  rlc_scan_map #(.SIDE(SIDE)) u_map (
    .pos   (pos),
    .bypass(scale_q == '0),
    .addr  (map_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= 1'b1;
      pend_q      <= 1'b0;
      pend_coef_q <= '0;
      scale_q     <= '0;
    end else if (close_blk) begin
      first_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (emit_coef) pend_q <= 1'b0;
      if (accept && (kind == WK_FIRST || kind == WK_RUN)) begin
        pend_q      <= 1'b1;
        pend_coef_q <= w_coef;
      end
      if (accept && kind == WK_FIRST) begin
        first_q <= 1'b0;
        scale_q <= w_field;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_coef  <= '0;
      out_scale <= '0;
      out_last  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_addr  <= map_addr;
      out_coef  <= emit_zero ? '0 : pend_coef_q;
      out_scale <= scale_q;
      out_last  <= pos_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign block_done = out_valid && out_ready && out_last;

  // R10: a stalled beat is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_coef) && $stable(out_scale) && $stable(out_last)));

  // R11: a taken non-padding word blocks input on the next cycle
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind != WK_PAD) |=> !in_ready);

  // R4: skipped positions are written as zero
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    emit_zero |=> (out_valid && out_coef == '0));

  // R9: completion is only signalled on the position-63 beat
  a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> (out_valid && out_last));

endmodule

// File: tb/rl_block_decoder_test.sv
`timescale 1ns/1ps
module rl_block_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  out_addr;
  logic [9:0]  out_coef;
  logic [5:0]  out_scale;
  logic        out_last;
  logic        block_done;

  always #10 clk = ~clk;

  rl_block_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_coef(out_coef), .out_scale(out_scale),
    .out_last(out_last), .block_done(block_done)
  );

  int checks = 0;
  int fails  = 0;

  logic [15:0] words [0:8191];
  logic        is_pad [0:8191];
  int nw = 0;

  logic [5:0] e_addr  [0:8191];
  logic [9:0] e_coef  [0:8191];
  logic [5:0] e_scale [0:8191];
  logic       e_last  [0:8191];
  string      e_tag   [0:8191];
  int ne = 0;

  int         m_pos = 0;
  logic [5:0] m_scale = '0;
  bit         m_open = 0;

  function automatic logic [5:0] zz(int k);
    int r = 0;
    int c = 0;
    bit up = 1;
    for (int s = 0; s < k; s++) begin
      if (up) begin
        if (c == 7)      begin r++; up = 0; end
        else if (r == 0) begin c++; up = 0; end
        else             begin r--; c++; end
      end else begin
        if (r == 7)      begin c++; up = 1; end
        else if (c == 0) begin r++; up = 1; end
        else             begin r++; c--; end
      end
    end
    return 6'(r*8 + c);
  endfunction

  task automatic push_word(logic [15:0] w, bit pad);
    words[nw] = w; is_pad[nw] = pad; nw++;
  endtask

  task automatic push_exp(logic [9:0] c, string tag);
    e_addr[ne]  = (m_scale == 0) ? 6'(m_pos) : zz(m_pos);
    e_coef[ne]  = c;
    e_scale[ne] = m_scale;
    e_last[ne]  = (m_pos == 63);
    e_tag[ne]   = tag;
    ne++;
    m_pos++;
    if (m_pos == 64) m_open = 0;
  endtask

  task automatic add_pad();
    push_word(16'hFE00, 1);
  endtask

  task automatic add_first(logic [5:0] s, logic [9:0] c, string tag);
    push_word({s, c}, 0);
    m_scale = s; m_pos = 0; m_open = 1;
    push_exp(c, tag);
  endtask

  task automatic add_word(int run, logic [9:0] c, string tag);
    string zt;
    zt = (m_pos + run > 63) ? "R6" : "R4";
    push_word({6'(run), c}, 0);
    for (int i = 0; i < run && m_open; i++) push_exp(10'd0, zt);
    if (m_open) push_exp(c, tag);
  endtask

  task automatic add_end();
    push_word(16'hFE00, 0);
    while (m_open) push_exp(10'd0, "R5");
  endtask

  task automatic driver();
    int  wi = 0;
    bit  taken = 0;
    bit  prev_np = 0;
    while (wi < nw || taken) begin
      @(negedge clk);
      if (prev_np) begin
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R11 in_ready after accepted word act %b exp 0", in_ready);
        end
      end
      prev_np = 0;
      if (taken) begin in_valid = 1'b0; taken = 0; end
      if (wi < nw && !in_valid && ($urandom % 4 != 0)) begin
        in_valid = 1'b1; in_data = words[wi];
      end
      #1;
      if (in_valid && in_ready) begin
        taken = 1;
        prev_np = !is_pad[wi];
        wi++;
      end
    end
  endtask

  task automatic monitor();
    int got = 0;
    bit held = 0;
    logic [5:0] h_addr; logic [9:0] h_coef; logic [5:0] h_scale; logic h_last;
    bit bad;
    while (got < ne) begin
      @(negedge clk);
      out_ready = ($urandom % 3 != 0);
      #1;
      if (held) begin
        checks++;
        if (!(out_valid === 1'b1 && out_addr === h_addr && out_coef === h_coef &&
              out_scale === h_scale && out_last === h_last)) begin
          fails++;
          $display("FAIL R10 held beat act v%b a%h c%h exp v1 a%h c%h",
                   out_valid, out_addr, out_coef, h_addr, h_coef);
        end
        held = 0;
      end
      if (out_valid && !out_ready) begin
        held = 1;
        h_addr = out_addr; h_coef = out_coef; h_scale = out_scale; h_last = out_last;
      end
      if (out_valid && out_ready) begin
        checks++;
        bad = 0;
        if (out_addr !== e_addr[got]) begin
          bad = 1;
          $display("FAIL %s beat %0d addr act %h exp %h",
                   (e_scale[got] == 0) ? "R8" : "R7", got, out_addr, e_addr[got]);
        end
        if (out_coef !== e_coef[got]) begin
          bad = 1;
          $display("FAIL %s beat %0d coef act %h exp %h", e_tag[got], got, out_coef, e_coef[got]);
        end
        if (out_scale !== e_scale[got]) begin
          bad = 1;
          $display("FAIL R2 beat %0d scale act %h exp %h", got, out_scale, e_scale[got]);
        end
        if (out_last !== e_last[got] || block_done !== e_last[got]) begin
          bad = 1;
          $display("FAIL R9 beat %0d last/done act %b/%b exp %b", got, out_last,
                   block_done, e_last[got]);
        end
        if (bad) fails++;
        got++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int run;
    logic [9:0] c;
    logic [5:0] s;
    void'($urandom(32'd2024));

    // R3: padding ahead of the first word, R1 sign extremes
    add_pad(); add_pad();
    add_first(6'd5, 10'h013, "R3");
    add_word(0, 10'h3FF, "R1");
    add_word(2, 10'h200, "R1");
    add_word(5, 10'h0AB, "R4");
    add_end();
    // R8: zero scale keeps addresses in position order
    add_first(6'd0, 10'h1FF, "R1");
    add_word(3, 10'h200, "R8");
    add_word(10, 10'h005, "R8");
    add_end();
    // R6: run overflow drops the coefficient
    add_first(6'd9, 10'h007, "R2");
    add_word(40, 10'h001, "R4");
    add_word(30, 10'h002, "R6");
    // R9: block filled entirely by coefficient words
    add_first(6'd1, 10'h001, "R2");
    for (int i = 1; i < 64; i++) add_word(0, 10'(i), "R9");
    // R5: immediate end code after the first word
    add_first(6'd63, 10'h2AA, "R2");
    add_end();

    for (int b = 0; b < 30; b++) begin
      if ($urandom % 5 == 0) add_pad();
      s = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom % 64);
      c = 10'($urandom);
      if (s == 6'd63 && c == 10'h200) c = 10'h001;
      add_first(s, c, "R2");
      while (m_open) begin
        if ($urandom % 12 == 0) add_end();
        else begin
          run = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 6);
          c = 10'($urandom);
          if (run == 63 && c == 10'h200) c = 10'h001;
          add_word(run, c, "R4");
        end
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || block_done !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 reset state act v%b d%b r%b exp v0 d0 r1",
               out_valid, block_done, in_ready);
    end

    fork
      driver();
      monitor();
    join

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule